// File: doc/BRIEF.md
# Cartridge Bank Mapping Controller

This block sits between a 24-bit CPU address bus and the memories of a cartridge. It keeps fourteen byte-wide mapping registers and, from them, turns every CPU address into a target select (work RAM, BIOS ROM, flash, PSRAM, SRAM, control I/O or nothing), a byte offset into that target, and a flag saying whether the target may be written there. The memories are outside the block: it only steers.

The registers live in two copies. Software writes land in a staged copy. A write that changes a register marks the map pending, and a nonzero write to the commit register copies the staged values into the active copy. Only the active copy drives translation, so software can rewrite several registers and switch the whole map at once. The pending state is held by a three-state commit machine. `ST_CLEAN` means nothing is pending. `ST_FAST` means only the BIOS overlay registers changed. `ST_FULL` means some other mapping register changed. The transitions are `CLEAN->FAST` (changed BIOS-overlay write), `CLEAN->FULL` and `FAST->FULL` (changed write to any other mapping register), and `FAST->CLEAN` or `FULL->CLEAN` (nonzero commit write). A fast commit copies only registers 7 and 8. A full commit copies all of them.

Top module: `bank_map_ctrl`

## Requirements
- R1: Register n (n = 1..14) is written and read back at CPU address {bank = n, offset 0x5000}. `reg_rdata_o` shows the staged value there and 0x00 at every other address, including bank 0x0F offset 0x5000.
- R2: A register write changes translation only after a commit. Until then, outputs reflect the previously active values.
- R3: A nonzero write to register 14 applies the staged registers when a change is pending, and clears the pending state. A zero write applies nothing.
- R4: When register 1 is nonzero, the program target is PSRAM (code 4) with offsets taken modulo 512 KB. When it is zero, the program target is flash (code 3) with offsets modulo 2 MB. Program space is banks 40-7F and C0-FF, plus offsets 0x8000-0xFFFF of banks 00-3F and 80-BF.
- R5: When register 2 is nonzero, program offset = {bank[5:0], addr[15:0]}. When it is zero, program offset = {bank[5:0], addr[14:0]}.
- R6: A nonzero register 7 maps BIOS (code 2, offset {bank[4:0], addr[14:0]}, read-only) at 0x8000-0xFFFF of banks 00-1F. Register 8 does the same for banks 80-9F.
- R7: Banks 70-77 map PSRAM at {bank[2:0], addr[15:0]}, and banks 20-3F at 0x6000-0x7FFF map it the same way. Banks 40-4F, 50-5F and 60-6F mirror PSRAM when register 5, 6 or 3 (respectively) is zero. The mirror offset is {bank[2:0], addr} when register 2 is nonzero and {bank[3:0], addr[14:0]} otherwise. PSRAM is writable.
- R8: SRAM (code 5) occupies banks 10-17 at 0x5000-0x5FFF with offset {bank[2:0], addr[11:0]}. Work RAM (code 1) occupies banks 7E-7F with offset {bank[0], addr} and 0x0000-0x1FFF of banks 00-3F/80-BF with offset addr[12:0]. Both are writable.
- R9: Banks 01-0E at 0x5000-0x5FFF give control I/O (code 6), not writable. Bank C0 gives writable control I/O when register 12 or 13 is nonzero.
- R10: Reset with BIOS boot sets registers 7 and 8 to 0x80 and all others to 0. Reset without BIOS boot sets register 14 to 0x80 and register 2 to 0x80 if the linear strap is high. With the PSRAM strap it also sets 1, 3, 4, 12 and 13 to 0x80; without it, 3, 5 and 6.
- R11: Program space is writable exactly when `flash_wr_en_i` is high. Addresses that no region claims give target code 0, offset 0, not writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| boot_bios_i | input | 1 | reset strap: start from BIOS |
| prog_psram_i | input | 1 | reset strap: program held in PSRAM |
| linear_i | input | 1 | reset strap: linear 64 KB banks |
| cpu_addr_i | input | 24 | CPU address {bank, offset} |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_we_i | input | 1 | CPU write strobe |
| reg_rdata_o | output | 8 | staged register read data |
| flash_wr_en_i | input | 1 | write permission from flash sequencer |
| tgt_sel_o | output | 3 | target code |
| tgt_off_o | output | 24 | byte offset in target |
| tgt_wr_o | output | 1 | target writable here |

## Verification
Several properties are checked on every cycle. In the clean state, the staged and active register copies agree. The active copy changes only on an apply. Fast and full applies never coincide, and each returns the machine to clean. BIOS hits are never writable, and PSRAM offsets stay below 512 KB. Other behaviour only the directed scenarios can show: the exact offset arithmetic per region, the region priorities, the masking of mirrors by registers 3, 5 and 6, the refusal of a zero commit, and the three reset images.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
    localparam int NREG    = 16;
    localparam int REG_W   = 8;
    localparam int IDX_W   = $clog2(NREG);
    localparam logic [REG_W-1:0] ON = 8'h80;

    // register roles (index = bank number of the register window)
    localparam int RI_SRC    = 1;
    localparam int RI_LIN    = 2;
    localparam int RI_M60    = 3;
    localparam int RI_PS4    = 4;
    localparam int RI_M40    = 5;
    localparam int RI_M50    = 6;
    localparam int RI_BLO    = 7;
    localparam int RI_BHI    = 8;
    localparam int RI_IOA    = 12;
    localparam int RI_IOB    = 13;
    localparam int RI_COMMIT = 14;

    localparam logic [NREG-1:0] WR_MASK   = 16'h7FFE;
    localparam logic [NREG-1:0] FULL_MASK = 16'h3E7E;
    localparam logic [NREG-1:0] FAST_MASK = 16'h0180;

    typedef enum logic [2:0] {
        TGT_NONE  = 3'd0,
        TGT_WRAM  = 3'd1,
        TGT_BIOS  = 3'd2,
        TGT_FLASH = 3'd3,
        TGT_PSRAM = 3'd4,
        TGT_SRAM  = 3'd5,
        TGT_CTRL  = 3'd6
    } tgt_e;

    typedef logic [NREG-1:0][REG_W-1:0] regset_t;

    function automatic regset_t reset_image(input logic bios_boot,
                                            input logic psram_prog,
                                            input logic linear);
        regset_t r;
        r = '0;
        if (bios_boot) begin
            r[RI_BLO] = ON;
            r[RI_BHI] = ON;
        end else begin
            r[RI_LIN]    = linear ? ON : '0;
            r[RI_COMMIT] = ON;
            r[RI_M60]    = ON;
            if (psram_prog) begin
                r[RI_SRC] = ON;
                r[RI_PS4] = ON;
                r[RI_IOA] = ON;
                r[RI_IOB] = ON;
            end else begin
                r[RI_M40] = ON;
                r[RI_M50] = ON;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/bmc_stage_regs.sv
module bmc_stage_regs
    import bmc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 boot_bios_i,
    input  logic                 prog_psram_i,
    input  logic                 linear_i,
    input  logic                 wr_en_i,
    input  logic [IDX_W-1:0]     wr_idx_i,
    input  logic [REG_W-1:0]     wr_data_i,
    output regset_t              staged_o,
    output logic                 full_chg_o,
    output logic                 fast_chg_o,
    output logic                 commit_req_o
);
    regset_t         staged;
    logic [NREG-1:0] changed;

    // per-register change detection
    for (genvar i = 0; i < NREG; i++) begin : g_chg
        assign changed[i] = wr_en_i && (wr_idx_i == IDX_W'(i))
                            && (staged[i] != wr_data_i);
    end

    assign full_chg_o   = |(changed & FULL_MASK);
    assign fast_chg_o   = |(changed & FAST_MASK);
    assign commit_req_o = wr_en_i && (wr_idx_i == IDX_W'(RI_COMMIT))
                          && (wr_data_i != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            staged <= reset_image(boot_bios_i, prog_psram_i, linear_i);
        end else if (wr_en_i && WR_MASK[wr_idx_i]) begin
            staged[wr_idx_i] <= wr_data_i;
        end
    end

    assign staged_o = staged;

    // R1: a window write lands in the addressed register on the next cycle
    assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && WR_MASK[wr_idx_i]) |=> (staged[$past(wr_idx_i)] == $past(wr_data_i)));
endmodule

// File: rtl/bmc_commit_fsm.sv
module bmc_commit_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic full_chg_i,
    input  logic fast_chg_i,
    input  logic commit_req_i,
    output logic apply_full_o,
    output logic apply_fast_o,
    output logic clean_o
);
    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_FAST  = 2'd1,
        ST_FULL  = 2'd2
    } cstate_e;

    cstate_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CLEAN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CLEAN: begin
                if (full_chg_i)      state_nx = ST_FULL;
                else if (fast_chg_i) state_nx = ST_FAST;
            end
            ST_FAST: begin
                if (commit_req_i)    state_nx = ST_CLEAN;
                else if (full_chg_i) state_nx = ST_FULL;
            end
            ST_FULL: begin
                if (commit_req_i)    state_nx = ST_CLEAN;
            end
            default:                 state_nx = ST_CLEAN;
        endcase
    end

    always_comb begin
        apply_full_o = 1'b0;
        apply_fast_o = 1'b0;
        clean_o      = 1'b0;
        unique case (state)
            ST_CLEAN: clean_o      = 1'b1;
            ST_FAST:  apply_fast_o = commit_req_i;
            ST_FULL:  apply_full_o = commit_req_i;
            default:  clean_o      = 1'b0;
        endcase
    end

    assert_apply_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({apply_full_o, apply_fast_o}));
    assert_apply_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_full_o || apply_fast_o) |=> clean_o);
endmodule

// File: rtl/bmc_active_map.sv
module bmc_active_map
    import bmc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    boot_bios_i,
    input  logic    prog_psram_i,
    input  logic    linear_i,
    input  regset_t staged_i,
    input  logic    apply_full_i,
    input  logic    apply_fast_i,
    output regset_t active_o
);
    regset_t active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= reset_image(boot_bios_i, prog_psram_i, linear_i);
        end else if (apply_full_i) begin
            active <= staged_i;
        end else if (apply_fast_i) begin
            active[RI_BLO] <= staged_i[RI_BLO];
            active[RI_BHI] <= staged_i[RI_BHI];
        end
    end

    assign active_o = active;

    // R2: translation state moves only on an apply
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!apply_full_i && !apply_fast_i) |=> $stable(active));
endmodule

// File: rtl/bmc_translate.sv
module bmc_translate
    import bmc_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int OFF_W    = 24,
    parameter int FLASH_AW = 21,
    parameter int PSRAM_AW = 19,
    parameter int BIOS_AW  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  r_src_i,
    input  logic [REG_W-1:0]  r_lin_i,
    input  logic [REG_W-1:0]  r_m40_i,
    input  logic [REG_W-1:0]  r_m50_i,
    input  logic [REG_W-1:0]  r_m60_i,
    input  logic [REG_W-1:0]  r_blo_i,
    input  logic [REG_W-1:0]  r_bhi_i,
    input  logic [REG_W-1:0]  r_ioa_i,
    input  logic [REG_W-1:0]  r_iob_i,
    input  logic              flash_wr_en_i,
    output tgt_e              tgt_o,
    output logic [OFF_W-1:0]  off_o,
    output logic              wr_o
);
    localparam logic [OFF_W-1:0] FLASH_MASK = OFF_W'((64'd1 << FLASH_AW) - 1);
    localparam logic [OFF_W-1:0] PSRAM_MASK = OFF_W'((64'd1 << PSRAM_AW) - 1);
    localparam logic [OFF_W-1:0] BIOS_MASK  = OFF_W'((64'd1 << BIOS_AW) - 1);
    localparam logic [OFF_W-1:0] PSRAM_SIZE = OFF_W'(64'd1 << PSRAM_AW);

    logic [7:0]  bank;
    logic [15:0] ofs;
    assign bank = addr_i[ADDR_W-1 -: 8];
    assign ofs  = addr_i[15:0];

    logic linear, src_psram;
    assign linear    = (r_lin_i != '0);
    assign src_psram = (r_src_i != '0);

    // region hits
    logic hit_wram_lo, hit_prog, hit_mirror, hit_ps_win, hit_ps_main;
    logic hit_sram, hit_wram_hi, hit_bios, hit_fio, hit_ctrl;

    assign hit_wram_lo = !bank[6] && (ofs[15:13] == 3'b000);
    assign hit_prog    = bank[6] || ofs[15];
    assign hit_mirror  = ((bank[7:4] == 4'h4) && (r_m40_i == '0))
                      || ((bank[7:4] == 4'h5) && (r_m50_i == '0))
                      || ((bank[7:4] == 4'h6) && (r_m60_i == '0));
    assign hit_ps_win  = (bank[7:5] == 3'b001) && (ofs[15:13] == 3'b011);
    assign hit_ps_main = (bank[7:3] == 5'b01110);
    assign hit_sram    = (bank[7:3] == 5'b00010) && (ofs[15:12] == 4'h5);
    assign hit_wram_hi = (bank[7:1] == 7'h3F);
    assign hit_bios    = ofs[15] && (((bank[7:5] == 3'b000) && (r_blo_i != '0))
                                  || ((bank[7:5] == 3'b100) && (r_bhi_i != '0)));
    assign hit_fio     = (bank == 8'hC0) && ((r_ioa_i != '0) || (r_iob_i != '0));
    assign hit_ctrl    = (bank >= 8'h01) && (bank <= 8'h0E) && (ofs[15:12] == 4'h5);

    // offsets
    logic [OFF_W-1:0] prog_raw, prog_off, mirror_off, ps_off, sram_off;
    logic [OFF_W-1:0] wram_hi_off, wram_lo_off, bios_off;

    assign prog_raw    = linear ? OFF_W'({bank[5:0], ofs})
                                : OFF_W'({bank[5:0], ofs[14:0]});
    assign prog_off    = prog_raw & (src_psram ? PSRAM_MASK : FLASH_MASK);
    assign mirror_off  = (linear ? OFF_W'({bank[2:0], ofs})
                                 : OFF_W'({bank[3:0], ofs[14:0]})) & PSRAM_MASK;
    assign ps_off      = OFF_W'({bank[2:0], ofs}) & PSRAM_MASK;
    assign sram_off    = OFF_W'({bank[2:0], ofs[11:0]});
    assign wram_hi_off = OFF_W'({bank[0], ofs});
    assign wram_lo_off = OFF_W'(ofs[12:0]);
    assign bios_off    = OFF_W'({bank[4:0], ofs[14:0]}) & BIOS_MASK;

    // later regions take precedence over earlier ones
    always_comb begin
        tgt_o = TGT_NONE;
        off_o = '0;
        wr_o  = 1'b0;
        if (hit_wram_lo) begin
            tgt_o = TGT_WRAM;  off_o = wram_lo_off; wr_o = 1'b1;
        end
        if (hit_prog) begin
            tgt_o = src_psram ? TGT_PSRAM : TGT_FLASH;
            off_o = prog_off;  wr_o = flash_wr_en_i;
        end
        if (hit_mirror) begin
            tgt_o = TGT_PSRAM; off_o = mirror_off;  wr_o = 1'b1;
        end
        if (hit_ps_win || hit_ps_main) begin
            tgt_o = TGT_PSRAM; off_o = ps_off;      wr_o = 1'b1;
        end
        if (hit_sram) begin
            tgt_o = TGT_SRAM;  off_o = sram_off;    wr_o = 1'b1;
        end
        if (hit_wram_hi) begin
            tgt_o = TGT_WRAM;  off_o = wram_hi_off; wr_o = 1'b1;
        end
        if (hit_bios) begin
            tgt_o = TGT_BIOS;  off_o = bios_off;    wr_o = 1'b0;
        end
        if (hit_fio) begin
            tgt_o = TGT_CTRL;  off_o = OFF_W'(ofs); wr_o = 1'b1;
        end
        if (hit_ctrl) begin
            tgt_o = TGT_CTRL;  off_o = OFF_W'(ofs); wr_o = 1'b0;
        end
    end

    assert_bios_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_o == TGT_BIOS) |-> !wr_o);
    assert_psram_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_o == TGT_PSRAM) |-> (off_o < PSRAM_SIZE));
    assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_o == TGT_NONE) |-> (!wr_o && off_o == '0));
endmodule

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl
    import bmc_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int OFF_W    = 24,
    parameter int FLASH_AW = 21,
    parameter int PSRAM_AW = 19,
    parameter int BIOS_AW  = 20,
    parameter logic [15:0] WIN_OFS = 16'h5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_bios_i,
    input  logic              prog_psram_i,
    input  logic              linear_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [REG_W-1:0]  cpu_wdata_i,
    input  logic              cpu_we_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    input  logic              flash_wr_en_i,
    output logic [2:0]        tgt_sel_o,
    output logic [OFF_W-1:0]  tgt_off_o,
    output logic              tgt_wr_o
);
    localparam int LAST_REG = RI_COMMIT;

    logic [7:0]       bank;
    logic             win_hit;
    logic [IDX_W-1:0] idx;

    assign bank    = cpu_addr_i[ADDR_W-1 -: 8];
    assign win_hit = (bank >= 8'd1) && (bank <= 8'(LAST_REG)) && (cpu_addr_i[15:0] == WIN_OFS);
    assign idx     = bank[IDX_W-1:0];

    regset_t staged, active;
    logic    full_chg, fast_chg, commit_req;
    logic    apply_full, apply_fast, clean;

    bmc_stage_regs u_stage (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_bios_i  (boot_bios_i),
        .prog_psram_i (prog_psram_i),
        .linear_i     (linear_i),
        .wr_en_i      (cpu_we_i && win_hit),
        .wr_idx_i     (idx),
        .wr_data_i    (cpu_wdata_i),
        .staged_o     (staged),
        .full_chg_o   (full_chg),
        .fast_chg_o   (fast_chg),
        .commit_req_o (commit_req)
    );

    bmc_commit_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .full_chg_i   (full_chg),
        .fast_chg_i   (fast_chg),
        .commit_req_i (commit_req),
        .apply_full_o (apply_full),
        .apply_fast_o (apply_fast),
        .clean_o      (clean)
    );

    bmc_active_map u_active (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_bios_i  (boot_bios_i),
        .prog_psram_i (prog_psram_i),
        .linear_i     (linear_i),
        .staged_i     (staged),
        .apply_full_i (apply_full),
        .apply_fast_i (apply_fast),
        .active_o     (active)
    );

    tgt_e tgt;

    bmc_translate #(
        .ADDR_W   (ADDR_W),
        .OFF_W    (OFF_W),
        .FLASH_AW (FLASH_AW),
        .PSRAM_AW (PSRAM_AW),
        .BIOS_AW  (BIOS_AW)
    ) u_xlate (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr_i        (cpu_addr_i),
        .r_src_i       (active[RI_SRC]),
        .r_lin_i       (active[RI_LIN]),
        .r_m40_i       (active[RI_M40]),
        .r_m50_i       (active[RI_M50]),
        .r_m60_i       (active[RI_M60]),
        .r_blo_i       (active[RI_BLO]),
        .r_bhi_i       (active[RI_BHI]),
        .r_ioa_i       (active[RI_IOA]),
        .r_iob_i       (active[RI_IOB]),
        .flash_wr_en_i (flash_wr_en_i),
        .tgt_o         (tgt),
        .off_o         (tgt_off_o),
        .wr_o          (tgt_wr_o)
    );

    assign tgt_sel_o   = tgt;
    assign reg_rdata_o = win_hit ? staged[idx] : '0;

    // registers with no translation role, kept only for readback
    logic unused_active;
    assign unused_active = ^{active[0], active[RI_PS4], active[9], active[10],
                             active[11], active[RI_COMMIT], active[15]};

    // R2: with nothing pending, staged and active mapping registers agree
    assert_clean_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clean |-> (staged[RI_IOB:RI_SRC] == active[RI_IOB:RI_SRC]));
endmodule

// File: tb/sim_bank_map_ctrl.sv
`timescale 1ns/1ps
module sim_bank_map_ctrl;
    localparam real HALF = 4.0;  // 125 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_bios = 1'b0, prog_psram = 1'b0, linear = 1'b0;
    logic [23:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        we = 1'b0;
    logic        fwe = 1'b0;
    logic [7:0]  rdata;
    logic [2:0]  tsel;
    logic [23:0] toff;
    logic        twr;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #(HALF) clk = ~clk;

    bank_map_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .boot_bios_i(boot_bios), .prog_psram_i(prog_psram),
        .linear_i(linear), .cpu_addr_i(addr), .cpu_wdata_i(wdata), .cpu_we_i(we),
        .reg_rdata_o(rdata), .flash_wr_en_i(fwe), .tgt_sel_o(tsel),
        .tgt_off_o(toff), .tgt_wr_o(twr)
    );

    localparam logic [2:0] T_NONE = 0, T_WRAM = 1, T_BIOS = 2, T_FLASH = 3,
                           T_PSRAM = 4, T_SRAM = 5, T_CTRL = 6;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_reset(input logic b, input logic p, input logic l);
        @(negedge clk);
        boot_bios = b; prog_psram = p; linear = l; rst_n = 1'b0; we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_reg(input logic [7:0] n, input logic [7:0] v);
        @(negedge clk);
        addr = {n, 16'h5000}; wdata = v; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic see_reg(input string tag, input logic [7:0] n, input logic [7:0] v);
        @(negedge clk);
        addr = {n, 16'h5000};
        #1 chk(tag, 32'(rdata), 32'(v));
    endtask

    task automatic see_map(input string tag, input logic [23:0] a, input logic [2:0] t,
                           input logic [23:0] o, input logic w);
        @(negedge clk);
        addr = a;
        #1;
        chk({tag, " sel"}, 32'(tsel), 32'(t));
        chk({tag, " off"}, 32'(toff), 32'(o));
        chk({tag, " wr"},  32'(twr),  32'(w));
    endtask

    task automatic t_reset_flash;
        do_reset(0, 0, 0);
        see_reg("R10 reg1",  8'h01, 8'h00);
        see_reg("R10 reg2",  8'h02, 8'h00);
        see_reg("R10 reg3",  8'h03, 8'h80);
        see_reg("R10 reg5",  8'h05, 8'h80);
        see_reg("R10 reg6",  8'h06, 8'h80);
        see_reg("R10 reg7",  8'h07, 8'h00);
        see_reg("R10 reg14", 8'h0E, 8'h80);
        see_reg("R1 bank0F", 8'h0F, 8'h00);
    endtask

    task automatic t_fixed_regions;
        see_map("R8 wram lo", 24'h001234, T_WRAM,  24'h001234, 1);
        see_map("R8 wram hi", 24'h7FABCD, T_WRAM,  24'h01ABCD, 1);
        see_map("R8 sram",    24'h125ABC, T_SRAM,  24'h002ABC, 1);
        see_map("R7 ps main", 24'h77FFFF, T_PSRAM, 24'h07FFFF, 1);
        see_map("R7 ps win",  24'h256001, T_PSRAM, 24'h056001, 1);
        see_map("R11 none",   24'h003000, T_NONE,  24'h000000, 0);
        see_map("R9 ctrl",    24'h055123, T_CTRL,  24'h005123, 0);
    endtask

    task automatic t_program_half;
        fwe = 1'b0;
        see_map("R4 flash base", 24'h008000, T_FLASH, 24'h000000, 0);
        see_map("R5 half top",   24'h3FFFFF, T_FLASH, 24'h1FFFFF, 0);
        see_map("R5 half hi",    24'h459234, T_FLASH, 24'h029234, 0);
        fwe = 1'b1;
        see_map("R11 prog wr",   24'h459234, T_FLASH, 24'h029234, 1);
        fwe = 1'b0;
    endtask

    task automatic t_staging;
        wr_reg(8'h05, 8'h00);
        see_reg("R1 reg5 staged", 8'h05, 8'h00);
        see_map("R2 before commit", 24'h410005, T_FLASH, 24'h008005, 0);
        wr_reg(8'h0E, 8'h00);
        see_map("R3 zero commit",   24'h410005, T_FLASH, 24'h008005, 0);
        wr_reg(8'h0E, 8'h01);
        see_map("R7 mirror on",     24'h410005, T_PSRAM, 24'h008005, 1);
        see_map("R7 c1 unaffected", 24'hC10005, T_FLASH, 24'h008005, 0);
    endtask

    task automatic t_bios;
        wr_reg(8'h07, 8'h80);
        see_map("R2 bios staged", 24'h008000, T_FLASH, 24'h000000, 0);
        wr_reg(8'h0E, 8'h80);
        see_map("R6 bios base", 24'h008000, T_BIOS,  24'h000000, 0);
        see_map("R6 bios top",  24'h1FFFFF, T_BIOS,  24'h0FFFFF, 0);
        see_map("R6 bank20",    24'h208000, T_FLASH, 24'h100000, 0);
        see_map("R6 bank80",    24'h808000, T_FLASH, 24'h000000, 0);
    endtask

    task automatic t_linear;
        wr_reg(8'h02, 8'h80);
        wr_reg(8'h0E, 8'h80);
        see_map("R5 linear",       24'hC11234, T_FLASH, 24'h011234, 0);
        see_map("R7 mirror lin",   24'h411234, T_PSRAM, 24'h011234, 1);
        see_map("R6 bios kept",    24'h008000, T_BIOS,  24'h000000, 0);
    endtask

    task automatic t_psram_src;
        wr_reg(8'h01, 8'h80);
        wr_reg(8'h0E, 8'h80);
        see_map("R4 psram wrap", 24'hC90000, T_PSRAM, 24'h010000, 0);
        see_map("R4 psram top",  24'hFFFFFF, T_PSRAM, 24'h07FFFF, 0);
    endtask

    task automatic t_flash_io;
        see_map("R9 c0 before", 24'hC02AAA, T_PSRAM, 24'h002AAA, 0);
        wr_reg(8'h0C, 8'h01);
        wr_reg(8'h0E, 8'h01);
        see_map("R9 c0 ctrl",   24'hC02AAA, T_CTRL,  24'h002AAA, 1);
    endtask

    task automatic t_reset_psram;
        do_reset(0, 1, 1);
        see_reg("R10 p reg1",  8'h01, 8'h80);
        see_reg("R10 p reg2",  8'h02, 8'h80);
        see_reg("R10 p reg5",  8'h05, 8'h00);
        see_reg("R10 p reg13", 8'h0D, 8'h80);
        see_map("R10 p prog",   24'h008000, T_PSRAM, 24'h008000, 0);
        see_map("R10 p mirror", 24'h410000, T_PSRAM, 24'h010000, 1);
        see_map("R10 p c0",     24'hC00000, T_CTRL,  24'h000000, 1);
    endtask

    task automatic t_reset_bios;
        do_reset(1, 0, 0);
        see_reg("R10 b reg7",  8'h07, 8'h80);
        see_reg("R10 b reg8",  8'h08, 8'h80);
        see_reg("R10 b reg14", 8'h0E, 8'h00);
        see_map("R6 b bank80", 24'h808000, T_BIOS, 24'h000000, 0);
        see_map("R6 b bank9F", 24'h9FFFFF, T_BIOS, 24'h0FFFFF, 0);
    endtask

    initial begin
        t_reset_flash();
        t_fixed_regions();
        t_program_half();
        t_staging();
        t_bios();
        t_linear();
        t_psram_src();
        t_flash_io();
        t_reset_psram();
        t_reset_bios();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(2.0 * HALF * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule